// File: doc/BRIEF.md
# Source-Route Port Decoder with Multi-Hop Setup Request

This block sits at a start router of a mesh network-on-chip where every packet carries a precomputed, static source route. The route holds 2 bits per router. When the local switch allocation picks a winning head flit, the block takes the low 2 bits of that flit's route and turns them into a one-hot output-port select. It also works out how far the flit may try to travel in one cycle: the setup request length, capped at a design-time maximum of hops per cycle.

The meaning of the 2-bit code depends on where the flit is. At the injection router it names an absolute compass port. At every later router it is relative to the side the flit arrived on: turn left, turn right, go straight, or eject to the local core. The block also hands on the route with the consumed field removed, so the next router again finds its own code in the low 2 bits. Decoding is combinational and all outputs are registered, so results appear one clock after the inputs.

Top module: `srcroute_ssr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears `port_sel`, `ssr_valid`, `ssr_len` and `route_out` to zero at the next rising edge, whatever the other inputs are.
- R2: Every output reflects the inputs sampled at the previous rising edge (one register stage).
- R3: With `at_source` high, route code 00 selects East, 01 South, 10 West and 11 North. `port_sel` bit 0 is East, bit 1 South, bit 2 West, bit 3 North and bit 4 the local core. The core bit is never set at the source.
- R4: With `at_source` low, `in_port` gives the arrival side (0 East, 1 South, 2 West, 3 North). Code 10 (straight) leaves by the side opposite the arrival side. Code 01 (right) leaves by the next side clockwise from straight, in the order East, South, West, North. Code 00 (left) leaves by the previous side in that order. Code 11 selects the core (bit 4).
- R5: When a request is issued, `ssr_len` equals the smaller of `HPC_MAX` and `hops_left`.
- R6: A winner with `hops_left` equal to zero produces `ssr_valid` low and `ssr_len` zero. The port select is still produced.
- R7: When `win_valid` is low, the next cycle shows `port_sel`, `ssr_valid`, `ssr_len` and `route_out` all zero.
- R8: The route code is `route_in[1:0]`. For a winner, `route_out` equals `route_in` shifted right by 2, with zeros in the top 2 bits.
- R9: For a winner, `port_sel` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 1 | A local allocation winner is present this cycle |
| route_in | input | 2*ROUTE_HOPS | Winner's remaining route; the low 2 bits are this router's code |
| hops_left | input | HOP_W | Hops the winner still has to travel |
| in_port | input | 2 | Side the winner arrived on (0 E, 1 S, 2 W, 3 N) |
| at_source | input | 1 | This router is the flit's injection point |
| port_sel | output | 5 | One-hot output port {core, N, W, S, E} |
| ssr_valid | output | 1 | A setup request is issued |
| ssr_len | output | HOP_W | Requested hop count for the setup request |
| route_out | output | 2*ROUTE_HOPS | Route with this hop's code removed |

## Verification
The checker checks these on every cycle: the one-hot port select for a winner, the all-zero outputs after an idle cycle, the cap and non-zero value of an issued request length, the suppression of a request for a zero hop count, the absence of the core port at the source, and the one-cycle route shift. Only the bench's scenarios show that each code maps to the correct side for each arrival side. The bench sweeps every combination of source flag, arrival side, code and hop count, and follows this with random routes and a reset that arrives while a winner is present.

// File: rtl/srcroute_ssr_gen.sv
module srcroute_ssr_gen #(
  parameter int HPC_MAX    = 4,
  parameter int ROUTE_HOPS = 8,
  parameter int HOP_W      = 4,
  localparam int RW        = 2 * ROUTE_HOPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_valid,
  input  logic [RW-1:0]    route_in,
  input  logic [HOP_W-1:0] hops_left,
  input  logic [1:0]       in_port,
  input  logic             at_source,
  output logic [4:0]       port_sel,
  output logic             ssr_valid,
  output logic [HOP_W-1:0] ssr_len,
  output logic [RW-1:0]    route_out
);

  localparam logic [HOP_W-1:0] CAP = HOP_W'(HPC_MAX);

  logic [1:0]       code, heading, abs_dir;
  logic             to_core;
  logic [4:0]       port_nxt;
  logic [HOP_W-1:0] len_nxt;

  assign code    = route_in[1:0];
  assign heading = in_port ^ 2'b10;

  always_comb begin
    to_core = 1'b0;
    abs_dir = code;
    if (!at_source) begin
      case (code)
        2'b00:   abs_dir = heading + 2'd3;
        2'b01:   abs_dir = heading + 2'd1;
        2'b10:   abs_dir = heading;
        default: begin abs_dir = heading; to_core = 1'b1; end
      endcase
    end
  end

  assign port_nxt = to_core ? 5'b10000 : {1'b0, 4'b0001 << abs_dir};
  assign len_nxt  = (hops_left > CAP) ? CAP : hops_left;

  always_ff @(posedge clk) begin
    if (rst || !win_valid) begin
      port_sel  <= '0;
      ssr_valid <= 1'b0;
      ssr_len   <= '0;
      route_out <= '0;
    end else begin
      port_sel  <= port_nxt;
      ssr_valid <= (hops_left != '0);
      ssr_len   <= (hops_left != '0) ? len_nxt : '0;
      route_out <= route_in >> 2;
    end
  end

endmodule

// File: rtl/srcroute_ssr_gen_chk.sv
module srcroute_ssr_gen_chk #(
  parameter int HPC_MAX    = 4,
  parameter int ROUTE_HOPS = 8,
  parameter int HOP_W      = 4,
  localparam int RW        = 2 * ROUTE_HOPS
) (
  input logic             clk,
  input logic             rst,
  input logic             win_valid,
  input logic [RW-1:0]    route_in,
  input logic [HOP_W-1:0] hops_left,
  input logic [1:0]       in_port,
  input logic             at_source,
  input logic [4:0]       port_sel,
  input logic             ssr_valid,
  input logic [HOP_W-1:0] ssr_len,
  input logic [RW-1:0]    route_out
);

  assert_onehot_pick_R9: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> ($countones(port_sel) == 1));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !win_valid |=> (port_sel == '0 && !ssr_valid && ssr_len == '0 && route_out == '0));

  assert_len_cap_R5: assert property (@(posedge clk) disable iff (rst)
    ssr_valid |-> (ssr_len != '0 && int'(ssr_len) <= HPC_MAX));

  assert_zero_hops_R6: assert property (@(posedge clk) disable iff (rst)
    (win_valid && hops_left == '0) |=> (!ssr_valid && ssr_len == '0));

  assert_src_no_core_R3: assert property (@(posedge clk) disable iff (rst)
    (win_valid && at_source) |=> !port_sel[4]);

  assert_route_shift_R8: assert property (@(posedge clk) disable iff (rst)
    win_valid |=> (route_out == ($past(route_in) >> 2)));

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (win_valid && hops_left != '0) |=> ssr_valid);

endmodule

bind srcroute_ssr_gen srcroute_ssr_gen_chk #(
  .HPC_MAX(HPC_MAX), .ROUTE_HOPS(ROUTE_HOPS), .HOP_W(HOP_W)
) chk_i (
  .clk(clk), .rst(rst), .win_valid(win_valid), .route_in(route_in),
  .hops_left(hops_left), .in_port(in_port), .at_source(at_source),
  .port_sel(port_sel), .ssr_valid(ssr_valid), .ssr_len(ssr_len),
  .route_out(route_out)
);

// File: tb/srcroute_ssr_gen_tb_top.sv
module srcroute_ssr_gen_tb_top;
  localparam int HPC_MAX = 4;
  localparam int HOPS    = 8;
  localparam int HOP_W   = 4;
  localparam int RW      = 2 * HOPS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic win_valid = 1'b0;
  logic [RW-1:0] route_in = '0;
  logic [HOP_W-1:0] hops_left = '0;
  logic [1:0] in_port = '0;
  logic at_source = 1'b0;
  logic [4:0] port_sel;
  logic ssr_valid;
  logic [HOP_W-1:0] ssr_len;
  logic [RW-1:0] route_out;

  always #5 clk = ~clk;

  srcroute_ssr_gen #(.HPC_MAX(HPC_MAX), .ROUTE_HOPS(HOPS), .HOP_W(HOP_W)) dut_i (
    .clk(clk), .rst(rst), .win_valid(win_valid), .route_in(route_in),
    .hops_left(hops_left), .in_port(in_port), .at_source(at_source),
    .port_sel(port_sel), .ssr_valid(ssr_valid), .ssr_len(ssr_len),
    .route_out(route_out));

  int compared = 0, mismatched = 0, cycles = 0;
  logic [4:0] e_port = '0;
  logic e_valid = 1'b0;
  int e_len = 0;
  logic [RW-1:0] e_route = '0;
  string e_tag = "R1";

  task automatic chk(string tag, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compass indices: 0 East, 1 South, 2 West, 3 North.
  function automatic int side_for(bit src, int arr, int code);
    int straight, leftd, rightd;
    if (src) return code;
    case (arr)
      0: begin straight = 2; leftd = 1; rightd = 3; end
      1: begin straight = 3; leftd = 2; rightd = 0; end
      2: begin straight = 0; leftd = 3; rightd = 1; end
      default: begin straight = 1; leftd = 0; rightd = 2; end
    endcase
    case (code)
      0: return leftd;
      1: return rightd;
      2: return straight;
      default: return 4;
    endcase
  endfunction

  task automatic step(bit r, bit w, logic [RW-1:0] rt, int h, int arr, bit src);
    @(negedge clk);
    chk({e_tag, " R2 port_sel"}, port_sel, e_port);
    chk({e_tag, " R2 ssr_valid"}, ssr_valid, e_valid);
    chk({e_tag, " R2 ssr_len"}, ssr_len, e_len);
    chk({e_tag, " R2 route_out"}, route_out, e_route);
    rst = r; win_valid = w; route_in = rt;
    hops_left = HOP_W'(h); in_port = 2'(arr); at_source = src;
    if (r) begin
      e_port = '0; e_valid = 0; e_len = 0; e_route = '0; e_tag = "R1";
    end else if (!w) begin
      e_port = '0; e_valid = 0; e_len = 0; e_route = '0; e_tag = "R7";
    end else begin
      e_port = 5'(1 << side_for(src, arr, int'(rt[1:0])));
      e_valid = (h != 0);
      e_len = (h == 0) ? 0 : ((h < HPC_MAX) ? h : HPC_MAX);
      e_route = {2'b00, rt[RW-1:2]};
      e_tag = (h == 0) ? "R6" : (src ? "R3 R5 R8 R9" : "R4 R5 R8 R9");
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    step(1, 0, '0, 0, 0, 0);
    step(1, 1, 16'hFFFF, 9, 2, 0);          // R1: reset wins over a winner
    step(0, 1, 16'hABCD, 15, 1, 0);
    step(1, 1, 16'h1234, 3, 0, 1);          // R1: reset mid-stream
    step(0, 0, 16'hFFFF, 7, 3, 1);          // R7: idle with busy inputs
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 4; c++)
          for (int h = 0; h < 16; h++)
            step(0, 1, {14'h2A5A ^ 14'(h * 97), 2'(c)}, h, a, s[0]);
    for (int i = 0; i < 400; i++)
      step(0, ($urandom % 4) != 0, RW'($urandom), int'($urandom % 16),
           int'($urandom % 4), $urandom % 2 == 1);
    step(0, 0, '0, 0, 0, 0);
    step(0, 0, '0, 0, 0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule